// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the device side of a two-port host interface to an embedded controller. The host selects one of two byte ports. The data port carries addresses, data and results. The other port returns a status byte on a read and accepts a command byte on a write. Flow control is a pair of buffer-full flags. The input flag says a host byte has not yet been consumed. The output flag says a result byte is waiting for the host.

A small sequencer interprets the commands and steps through the bytes that follow them. The commands are a register read, a register write, burst on, burst off, and an event query. Reads and writes reach a 256-entry byte register space through a synchronous port with one cycle of read latency. A vector of event inputs feeds a pending set, which the query command drains one event at a time, lowest number first.

Top module: `ecHostIf`

## Requirements
- R1: After reset the status byte reads 0x00. Status layout: bit 0 = output full, bit 1 = input full, bit 3 = last host write went to the command port, bit 4 = burst flag, bit 5 = any event pending, bits 2, 6 and 7 read 0. hostSel=0 selects the data port and hostSel=1 selects the status/command port.
- R2: A host write to either port sets input-full at the next clock edge. With CONSUME_CYC=2, input-full reads 1 for two cycles after the write edge and clears at the second edge after it.
- R3: Status bit 3 reads 1 after a command-port write and 0 after a data-port write.
- R4: Command 0x80 followed by one address byte on the data port places the register at that address in the data port and sets output-full.
- R5: A host read of the data port clears output-full at the next edge.
- R6: Command 0x81 followed by an address byte and then a data byte stores the data byte at that address.
- R7: Command 0x82 places 0x90 in the data port, sets output-full and sets the burst flag. Command 0x83 clears the burst flag and does not set output-full.
- R8: Command 0x84 returns the lowest pending event (input line i is reported as i+1), or 0x00 when none is pending, sets output-full, and removes that event from the pending set.
- R9: A data-port byte that arrives while no command is in progress causes no register write and does not set output-full.
- R10: A command byte abandons any partly received sequence. An unrecognised command byte starts nothing, so the data bytes that follow it are ignored.
- R11: A high evtSet line marks its event pending at the next edge, and status bit 5 then reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe, one cycle per byte |
| hostRd | input | 1 | Host read strobe, one cycle per byte |
| hostSel | input | 1 | 0 = data port, 1 = status/command port |
| hostWdata | input | 8 | Byte written by the host |
| hostRdata | output | 8 | Data byte or status byte, chosen by hostSel |
| evtSet | input | NUM_EVT | Event request lines |
| regAddr | output | 8 | Register space address |
| regWdata | output | 8 | Register space write data |
| regWe | output | 1 | Register space write enable |
| regRe | output | 1 | Register space read enable; data is due one cycle later |
| regRdata | input | 8 | Register space read data |

## Verification
A sequencer left in the wrong state shows up at the ports within one transaction. A read then returns a byte that differs from the register model, a write lands at the wrong address, or a stray byte causes a register write. A stuck buffer-full flag shows up as a poll that never completes within its bound, so it is reported within tens of cycles. An error in the event priority or the pending-set clear shows up in the order of the query results and in status bit 5 once the set drains.

// File: rtl/ecHostPkg.sv
package ecHostPkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_READ   = 8'h80;
  localparam logic [BYTE_W-1:0] OP_WRITE  = 8'h81;
  localparam logic [BYTE_W-1:0] OP_BURST1 = 8'h82;
  localparam logic [BYTE_W-1:0] OP_BURST0 = 8'h83;
  localparam logic [BYTE_W-1:0] OP_QUERY  = 8'h84;
  localparam logic [BYTE_W-1:0] BURST_ACK = 8'h90;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ADDR,
    ST_RD_REQ,
    ST_RD_LOAD,
    ST_WR_ADDR,
    ST_WR_DATA
  } seqStateT;

  typedef struct packed {
    logic take;       // consume the pending host byte
    logic latchAddr;  // capture the pending byte as register address
    logic regRe;      // issue register read
    logic regWe;      // issue register write
    logic loadRead;   // register data into output byte
    logic loadAck;    // burst acknowledge into output byte
    logic loadQuery;  // query result into output byte
    logic burstSet;
    logic burstClr;
  } ecStrobeT;
endpackage

// File: rtl/ecControl.sv
module ecControl
  import ecHostPkg::*;
#(
  parameter int CONSUME_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              ibf,
  input  logic              cmdBit,
  input  logic [BYTE_W-1:0] inByte,
  output ecStrobeT          strb
);
  localparam int CNT_W = $clog2(CONSUME_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONSUME_CYC - 1);

  seqStateT state, nextState;
  logic [CNT_W-1:0] dwellCnt;
  logic busy;
  logic take;

  // dwell counter: restarts on every host write, saturates at CNT_LAST
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dwellCnt <= '0;
    end else if (hostWr) begin
      dwellCnt <= '0;
    end else if (ibf && dwellCnt != CNT_LAST) begin
      dwellCnt <= dwellCnt + 1'b1;
    end
  end

  assign busy = (state == ST_RD_REQ) || (state == ST_RD_LOAD);
  assign take = ibf && !hostWr && (dwellCnt == CNT_LAST) && !busy;

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_RD_REQ: begin
        strb.regRe = 1'b1;
        nextState  = ST_RD_LOAD;
      end
      ST_RD_LOAD: begin
        strb.loadRead = 1'b1;
        nextState     = ST_IDLE;
      end
      default: ;
    endcase
    if (take) begin
      strb.take = 1'b1;
      if (cmdBit) begin
        nextState = ST_IDLE;
        case (inByte)
          OP_READ:   nextState = ST_RD_ADDR;
          OP_WRITE:  nextState = ST_WR_ADDR;
          OP_BURST1: begin
            strb.burstSet = 1'b1;
            strb.loadAck  = 1'b1;
          end
          OP_BURST0: strb.burstClr  = 1'b1;
          OP_QUERY:  strb.loadQuery = 1'b1;
          default: ;
        endcase
      end else begin
        case (state)
          ST_RD_ADDR: begin
            strb.latchAddr = 1'b1;
            nextState      = ST_RD_REQ;
          end
          ST_WR_ADDR: begin
            strb.latchAddr = 1'b1;
            nextState      = ST_WR_DATA;
          end
          ST_WR_DATA: begin
            strb.regWe = 1'b1;
            nextState  = ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/ecDatapath.sv
module ecDatapath
  import ecHostPkg::*;
#(
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWr,
  input  logic               hostRd,
  input  logic               hostSel,
  input  logic [BYTE_W-1:0]  hostWdata,
  input  logic [NUM_EVT-1:0] evtSet,
  input  logic [BYTE_W-1:0]  regRdata,
  input  ecStrobeT           strb,
  output logic [BYTE_W-1:0]  inByte,
  output logic               cmdBit,
  output logic               ibf,
  output logic [BYTE_W-1:0]  statusByte,
  output logic [BYTE_W-1:0]  outByte,
  output logic [BYTE_W-1:0]  regAddr,
  output logic [BYTE_W-1:0]  regWdata
);
  logic obf;
  logic burst;
  logic [BYTE_W-1:0]  addrLatch;
  logic [NUM_EVT-1:0] pending;
  logic [NUM_EVT-1:0] lowestHot;
  logic [BYTE_W-1:0]  queryCode;

  // lowest pending event, reported as index + 1
  always_comb begin
    lowestHot = '0;
    queryCode = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (pending[i]) begin
        lowestHot    = '0;
        lowestHot[i] = 1'b1;
        queryCode    = BYTE_W'(i + 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inByte <= '0;
      cmdBit <= 1'b0;
      ibf    <= 1'b0;
    end else if (hostWr) begin
      inByte <= hostWdata;
      cmdBit <= hostSel;
      ibf    <= 1'b1;
    end else if (strb.take) begin
      ibf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      obf     <= 1'b0;
      outByte <= '0;
    end else if (strb.loadRead) begin
      obf     <= 1'b1;
      outByte <= regRdata;
    end else if (strb.loadAck) begin
      obf     <= 1'b1;
      outByte <= BURST_ACK;
    end else if (strb.loadQuery) begin
      obf     <= 1'b1;
      outByte <= queryCode;
    end else if (hostRd && !hostSel) begin
      obf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burst     <= 1'b0;
      addrLatch <= '0;
      pending   <= '0;
    end else begin
      if (strb.burstSet)      burst <= 1'b1;
      else if (strb.burstClr) burst <= 1'b0;
      if (strb.latchAddr) addrLatch <= inByte;
      pending <= (pending & ~(strb.loadQuery ? lowestHot : '0)) | evtSet;
    end
  end

  assign statusByte = {2'b00, |pending, burst, cmdBit, 1'b0, ibf, obf};
  assign regAddr    = addrLatch;
  assign regWdata   = inByte;
endmodule

// File: rtl/ecHostIf.sv
module ecHostIf
  import ecHostPkg::*;
#(
  parameter int CONSUME_CYC = 2,
  parameter int NUM_EVT     = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWr,
  input  logic               hostRd,
  input  logic               hostSel,
  input  logic [7:0]         hostWdata,
  output logic [7:0]         hostRdata,
  input  logic [NUM_EVT-1:0] evtSet,
  output logic [7:0]         regAddr,
  output logic [7:0]         regWdata,
  output logic               regWe,
  output logic               regRe,
  input  logic [7:0]         regRdata
);
  ecStrobeT strb;
  logic [BYTE_W-1:0] inByte;
  logic [BYTE_W-1:0] statusByte;
  logic [BYTE_W-1:0] outByte;
  logic cmdBit;
  logic ibf;

  ecControl #(.CONSUME_CYC(CONSUME_CYC)) ctrlI (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .ibf(ibf),
    .cmdBit(cmdBit), .inByte(inByte), .strb(strb)
  );

  ecDatapath #(.NUM_EVT(NUM_EVT)) dpI (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostSel(hostSel), .hostWdata(hostWdata), .evtSet(evtSet),
    .regRdata(regRdata), .strb(strb), .inByte(inByte), .cmdBit(cmdBit),
    .ibf(ibf), .statusByte(statusByte), .outByte(outByte),
    .regAddr(regAddr), .regWdata(regWdata)
  );

  assign regWe     = strb.regWe;
  assign regRe     = strb.regRe;
  assign hostRdata = hostSel ? statusByte : outByte;
endmodule

// File: rtl/ecHostIf_chk.sv
module ecHostIf_chk #(
  parameter int NUM_EVT = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostWr,
  input logic [NUM_EVT-1:0] evtSet,
  input logic               regWe,
  input logic               regRe,
  input logic [7:0]         status
);
  // R2
  ibf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostWr |=> status[1]);

  // R6
  wr_only_on_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> (status[1] && !status[3]));

  // R4
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWe, regRe}));

  // R7
  burst_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[4]) |-> status[0]);

  // R11
  evt_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|evtSet) |=> status[5]);
endmodule

bind ecHostIf ecHostIf_chk #(.NUM_EVT(NUM_EVT)) chkI (
  .clk(clk), .rstN(rstN), .hostWr(hostWr), .evtSet(evtSet),
  .regWe(regWe), .regRe(regRe), .status(statusByte)
);

// File: tb/ecHostIf_test.sv
module ecHostIf_test;
  localparam int NUM_EVT = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWr = 1'b0, hostRd = 1'b0, hostSel = 1'b1;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic [NUM_EVT-1:0] evtSet = '0;
  logic [7:0] regAddr, regWdata, regRdata;
  logic regWe, regRe;

  int errors = 0;
  int checks = 0;
  int weCount = 0;
  logic [7:0] mem [256];
  logic [7:0] refMem [256];

  always #2 clk = ~clk;

  ecHostIf #(.CONSUME_CYC(2), .NUM_EVT(NUM_EVT)) uut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostSel(hostSel), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .evtSet(evtSet), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRe(regRe), .regRdata(regRdata)
  );

  function automatic logic [7:0] initVal(int a);
    return 8'((a * 7 + 3) & 8'hff);
  endfunction

  function automatic logic [7:0] expQuery(logic [NUM_EVT-1:0] p);
    for (int i = 0; i < NUM_EVT; i++) if (p[i]) return 8'(i + 1);
    return 8'h00;
  endfunction

  // register space model driven by the design's port
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= initVal(i);
      regRdata <= '0;
    end else begin
      if (regWe) begin
        mem[regAddr] <= regWdata;
        weCount <= weCount + 1;
      end
      if (regRe) regRdata <= mem[regAddr];
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic status(output logic [7:0] s);
    hostSel = 1'b1;
    #1 s = hostRdata;
  endtask

  task automatic waitFlag(int bitIdx, logic want, string tag);
    logic [7:0] s;
    for (int n = 0; n < 60; n++) begin
      status(s);
      if (s[bitIdx] == want) return;
      @(negedge clk);
    end
    errors++; checks++;
    $display("FAIL %s actual=%0d expected=%0d (poll timeout)", tag, !want, want);
  endtask

  task automatic hostWrite(logic sel, logic [7:0] b);
    waitFlag(1, 1'b0, "R2");
    @(negedge clk);
    hostSel = sel; hostWdata = b; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0; hostSel = 1'b1;
  endtask

  task automatic hostReadData(output logic [7:0] v);
    waitFlag(0, 1'b1, "R4");
    @(negedge clk);
    hostSel = 1'b0; hostRd = 1'b1;
    #1 v = hostRdata;
    @(negedge clk);
    hostRd = 1'b0; hostSel = 1'b1;
  endtask

  task automatic readReg(logic [7:0] a, output logic [7:0] v);
    hostWrite(1'b1, 8'h80);
    hostWrite(1'b0, a);
    hostReadData(v);
  endtask

  task automatic writeReg(logic [7:0] a, logic [7:0] d);
    hostWrite(1'b1, 8'h81);
    hostWrite(1'b0, a);
    hostWrite(1'b0, d);
    waitFlag(1, 1'b0, "R6");
    refMem[a] = d;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] s, v;
    logic [NUM_EVT-1:0] pendModel;
    int wb;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) refMem[i] = initVal(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    status(s);
    check("R1 status after reset", s, 8'h00);

    // R2 / R3 IBF timing and command flag
    @(negedge clk);
    hostSel = 1'b1; hostWdata = 8'h83; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
    status(s); check("R2 ibf 1st cycle", {7'd0, s[1]}, 8'd1);
    check("R3 cmd flag set", {7'd0, s[3]}, 8'd1);
    @(negedge clk);
    status(s); check("R2 ibf 2nd cycle", {7'd0, s[1]}, 8'd1);
    @(negedge clk);
    status(s); check("R2 ibf cleared", {7'd0, s[1]}, 8'd0);

    // R9 stray data byte: no write, no OBF, R3 flag goes low
    wb = weCount;
    hostWrite(1'b0, 8'hAB);
    status(s); check("R3 data flag", {7'd0, s[3]}, 8'd0);
    repeat (6) @(negedge clk);
    status(s); check("R9 no obf", {7'd0, s[0]}, 8'd0);
    check("R9 no reg write", 8'(weCount - wb), 8'd0);

    // R4 / R6 directed corners
    writeReg(8'h00, 8'h5A);
    check("R6 mem[00]", mem[8'h00], 8'h5A);
    writeReg(8'hFF, 8'hC3);
    check("R6 mem[FF]", mem[8'hFF], 8'hC3);
    readReg(8'hFF, v); check("R4 read FF", v, 8'hC3);
    status(s); check("R5 obf cleared", {7'd0, s[0]}, 8'd0);
    readReg(8'h10, v); check("R4 read 10", v, refMem[8'h10]);

    // random mix of reads and writes
    for (int k = 0; k < 40; k++) begin
      logic [7:0] a, d;
      a = 8'($urandom);
      d = 8'($urandom);
      if ($urandom % 2 == 0) begin
        writeReg(a, d);
        check("R6 random write", mem[a], d);
      end else begin
        readReg(a, v);
        check("R4 random read", v, refMem[a]);
      end
    end

    // R7 burst on/off
    hostWrite(1'b1, 8'h82);
    waitFlag(0, 1'b1, "R7");
    status(s); check("R7 burst flag on", {7'd0, s[4]}, 8'd1);
    hostReadData(v); check("R7 ack byte", v, 8'h90);
    status(s); check("R5 obf cleared after ack", {7'd0, s[0]}, 8'd0);
    hostWrite(1'b1, 8'h83);
    waitFlag(1, 1'b0, "R7");
    repeat (3) @(negedge clk);
    status(s); check("R7 burst flag off", {7'd0, s[4]}, 8'd0);
    check("R7 no obf on disable", {7'd0, s[0]}, 8'd0);

    // R8 query with nothing pending
    hostWrite(1'b1, 8'h84);
    hostReadData(v); check("R8 empty query", v, 8'h00);

    // R11 / R8 events 2 and 5, then 0
    pendModel = '0;
    @(negedge clk);
    evtSet = 8'b0010_0100;
    @(negedge clk);
    evtSet = '0;
    pendModel = 8'b0010_0100;
    status(s); check("R11 pending flag", {7'd0, s[5]}, 8'd1);
    for (int q = 0; q < 3; q++) begin
      logic [7:0] e;
      e = expQuery(pendModel);
      hostWrite(1'b1, 8'h84);
      hostReadData(v); check("R8 query order", v, e);
      if (e != 0) pendModel[e - 1] = 1'b0;
    end
    status(s); check("R8 pending drained", {7'd0, s[5]}, 8'd0);
    @(negedge clk);
    evtSet = 8'b1000_0001;
    @(negedge clk);
    evtSet = '0;
    hostWrite(1'b1, 8'h84);
    hostReadData(v); check("R8 lowest of 0 and 7", v, 8'h01);
    hostWrite(1'b1, 8'h84);
    hostReadData(v); check("R8 next is 7", v, 8'h08);

    // R10 abort partial write with a read command
    wb = weCount;
    hostWrite(1'b1, 8'h81);
    hostWrite(1'b0, 8'h22);
    hostWrite(1'b1, 8'h80);
    hostWrite(1'b0, 8'h33);
    hostReadData(v); check("R10 abort then read", v, refMem[8'h33]);
    check("R10 no write after abort", 8'(weCount - wb), 8'd0);
    // R10 unknown command discards sequence
    hostWrite(1'b1, 8'h81);
    hostWrite(1'b0, 8'h44);
    hostWrite(1'b1, 8'h55);
    hostWrite(1'b0, 8'hEE);
    waitFlag(1, 1'b0, "R10");
    repeat (4) @(negedge clk);
    check("R10 unknown cmd no write", 8'(weCount - wb), 8'd0);
    check("R10 mem[44] unchanged", mem[8'h44], refMem[8'h44]);
    status(s); check("R10 no obf", {7'd0, s[0]}, 8'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule